// File: doc/BRIEF.md
# Aliased Partial-Width General Register File

This block holds eight 64-bit general registers and lets each access name a register through a 3-bit selector combined with an operand size. The supported sizes are 8, 16, 32 and 64 bits. A flag marks whether an extension prefix is present. The block maps each access onto one physical register and one bit slice of it.

At 8-bit size the upper half of the selector space is overloaded. Without the prefix, selectors 4 to 7 reach the second byte of the first four registers. With the prefix, the same selectors reach the low byte of the last four registers. Wider sizes always name the low 16, the low 32 or all 64 bits of the selected register. No alias exists for bits 31:16 or 23:16 alone.

There are two read ports, called source and destination, and one merging write port. Both read ports return data right-justified and zero-extended, registered one cycle after the request. A write lands at the clock edge. A read presented in the same cycle as a write returns the value from before that write.

Top module: `alias_regfile`

## Requirements
- R1: A synchronous active-high reset clears all eight registers and both read outputs to zero.
- R2: At size code 0 (8 bits), selectors 0..3 read or write bits 7:0 of physical registers 0..3, whether or not the prefix is present.
- R3: At size code 0 with the prefix flag low, selectors 4..7 read or write bits 15:8 of physical registers 0..3 (selector minus 4).
- R4: At size code 0 with the prefix flag high, selectors 4..7 read or write bits 7:0 of physical registers 4..7.
- R5: At size codes 1 (16 bits), 2 (32 bits) and 3 (64 bits), the selector names the physical register of the same number, and the prefix flag has no effect. Each of these sizes addresses its low 16 bits, its low 32 bits or all 64 bits.
- R6: An 8-bit or 16-bit write changes only the addressed slice. Every other bit of that register, including bits 63:16, keeps its value.
- R7: A 32-bit write stores the low 32 bits of the write data and clears bits 63:32 of the register.
- R8: A 64-bit write replaces the entire register with the write data.
- R9: Read data is the addressed slice, shifted down to bit 0, with every bit above the slice width equal to zero.
- R10: Read outputs appear one clock after the request. A write in the same cycle is not visible in that read, but is visible one cycle later. The two read ports are independent, and only the written register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_sel | input | 3 | Source read selector |
| src_size | input | 2 | Source operand size code (0=8, 1=16, 2=32, 3=64) |
| src_pfx | input | 1 | Source extension prefix flag |
| dst_sel | input | 3 | Destination read selector |
| dst_size | input | 2 | Destination operand size code |
| dst_pfx | input | 1 | Destination extension prefix flag |
| wr_en | input | 1 | Write enable |
| wr_sel | input | 3 | Write selector |
| wr_size | input | 2 | Write operand size code |
| wr_pfx | input | 1 | Write extension prefix flag |
| wr_data | input | 64 | Write data, right-justified |
| src_data | output | 64 | Registered source read data |
| dst_data | output | 64 | Registered destination read data |

## Verification
The bench goes after the overloaded 8-bit selectors 4 to 7. It reads and writes them with and without the prefix after filling every register with a distinct 64-bit pattern. A design that ignored the prefix would hit the wrong register. A design that mixed up the byte lane would return or modify bits 7:0 where bits 15:8 were meant.

Narrow writes into full registers expose missing merge logic, which would clobber the upper bits. A 32-bit write over an all-ones register catches a missing zero-extension. Reads paired with a same-cycle write to the same register pin down the read-before-write timing. A long random mix of sizes, selectors and prefixes, checked against a reference model, covers the interactions among all of these.

// File: rtl/alias_rf_pkg.sv
package alias_rf_pkg;
  typedef enum logic [1:0] {
    OP8  = 2'd0,
    OP16 = 2'd1,
    OP32 = 2'd2,
    OP64 = 2'd3
  } opsz_e;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned HALF_W = 16;
endpackage

// File: rtl/alias_rf_decode.sv
module alias_rf_decode #(
  parameter int unsigned SELW = 3
) (
  input  logic [SELW-1:0] sel,
  input  logic [1:0]      size,
  input  logic            pfx,
  output logic [SELW-1:0] idx,
  output logic            hi
);
  import alias_rf_pkg::*;

  // Upper byte alias: narrow size, upper selector half, no prefix
  always_comb begin
    hi  = (opsz_e'(size) == OP8) && sel[SELW-1] && !pfx;
    idx = hi ? {1'b0, sel[SELW-2:0]} : sel;
  end
endmodule

// File: rtl/alias_rf_merge.sv
module alias_rf_merge #(
  parameter int unsigned XLEN = 64
) (
  input  logic [XLEN-1:0] old_val,
  input  logic [XLEN-1:0] wdata,
  input  logic [1:0]      size,
  input  logic            hi,
  output logic [XLEN-1:0] new_val
);
  import alias_rf_pkg::*;
  localparam int unsigned WORD_W = XLEN / 2;

  always_comb begin
    new_val = old_val;
    unique case (opsz_e'(size))
      OP8: begin
        if (hi) new_val[2*BYTE_W-1:BYTE_W] = wdata[BYTE_W-1:0];
        else    new_val[BYTE_W-1:0]        = wdata[BYTE_W-1:0];
      end
      OP16:    new_val[HALF_W-1:0] = wdata[HALF_W-1:0];
      OP32:    new_val = XLEN'(wdata[WORD_W-1:0]);
      default: new_val = wdata;
    endcase
  end
endmodule

// File: rtl/alias_rf_rdport.sv
module alias_rf_rdport #(
  parameter int unsigned XLEN = 64,
  parameter int unsigned NREG = 8,
  localparam int unsigned SELW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [SELW-1:0] sel,
  input  logic [1:0]      size,
  input  logic            pfx,
  input  logic [XLEN-1:0] regs [NREG],
  output logic [XLEN-1:0] data_q
);
  import alias_rf_pkg::*;
  localparam int unsigned WORD_W = XLEN / 2;

  logic [SELW-1:0] idx;
  logic            hi;
  logic [XLEN-1:0] word;
  logic [XLEN-1:0] slice;

  alias_rf_decode #(.SELW(SELW)) u_dec (
    .sel  (sel),
    .size (size),
    .pfx  (pfx),
    .idx  (idx),
    .hi   (hi)
  );

  always_comb begin
    word = regs[idx];
    unique case (opsz_e'(size))
      OP8:     slice = hi ? XLEN'(word[2*BYTE_W-1:BYTE_W]) : XLEN'(word[BYTE_W-1:0]);
      OP16:    slice = XLEN'(word[HALF_W-1:0]);
      OP32:    slice = XLEN'(word[WORD_W-1:0]);
      default: slice = word;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) data_q <= '0;
    else     data_q <= slice;
  end
endmodule

// File: rtl/alias_regfile.sv
module alias_regfile #(
  parameter int unsigned XLEN = 64,
  parameter int unsigned NREG = 8,
  localparam int unsigned SELW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [2:0]      src_sel,
  input  logic [1:0]      src_size,
  input  logic            src_pfx,
  input  logic [2:0]      dst_sel,
  input  logic [1:0]      dst_size,
  input  logic            dst_pfx,
  input  logic            wr_en,
  input  logic [2:0]      wr_sel,
  input  logic [1:0]      wr_size,
  input  logic            wr_pfx,
  input  logic [XLEN-1:0] wr_data,
  output logic [XLEN-1:0] src_data,
  output logic [XLEN-1:0] dst_data
);
  localparam int unsigned NRD = 2;

  logic [XLEN-1:0] regs_q [NREG];
  logic [SELW-1:0] rp_sel  [NRD];
  logic [1:0]      rp_size [NRD];
  logic            rp_pfx  [NRD];
  logic [XLEN-1:0] rp_data [NRD];

  always_comb begin
    rp_sel[0]  = SELW'(src_sel);
    rp_size[0] = src_size;
    rp_pfx[0]  = src_pfx;
    rp_sel[1]  = SELW'(dst_sel);
    rp_size[1] = dst_size;
    rp_pfx[1]  = dst_pfx;
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    alias_rf_rdport #(.XLEN(XLEN), .NREG(NREG)) u_rd (
      .clk    (clk),
      .rst    (rst),
      .sel    (rp_sel[p]),
      .size   (rp_size[p]),
      .pfx    (rp_pfx[p]),
      .regs   (regs_q),
      .data_q (rp_data[p])
    );
  end

  assign src_data = rp_data[0];
  assign dst_data = rp_data[1];

  // Write path: decode, read-modify-merge, store
  logic [SELW-1:0] w_idx;
  logic            w_hi;
  logic [XLEN-1:0] w_new;

  alias_rf_decode #(.SELW(SELW)) u_wdec (
    .sel  (SELW'(wr_sel)),
    .size (wr_size),
    .pfx  (wr_pfx),
    .idx  (w_idx),
    .hi   (w_hi)
  );

  alias_rf_merge #(.XLEN(XLEN)) u_merge (
    .old_val (regs_q[w_idx]),
    .wdata   (wr_data),
    .size    (wr_size),
    .hi      (w_hi),
    .new_val (w_new)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else if (wr_en) begin
      regs_q[w_idx] <= w_new;
    end
  end
endmodule

// File: rtl/alias_regfile_chk.sv
module alias_regfile_chk #(
  parameter int unsigned XLEN = 64,
  parameter int unsigned NREG = 8
) (
  input logic            clk,
  input logic            rst,
  input logic [1:0]      src_size,
  input logic [1:0]      dst_size,
  input logic            wr_en,
  input logic [2:0]      wr_sel,
  input logic [1:0]      wr_size,
  input logic            wr_pfx,
  input logic [XLEN-1:0] wr_data,
  input logic [XLEN-1:0] src_data,
  input logic [XLEN-1:0] dst_data,
  input logic [XLEN-1:0] regs_q [NREG]
);
  logic [2:0] tgt;
  assign tgt = (wr_size == 2'd0 && !wr_pfx && wr_sel >= 3'd4) ? wr_sel - 3'd4 : wr_sel;

  // R1
  rst_clears_out_chk: assert property (@(posedge clk)
    $past(rst) |-> (src_data == '0 && dst_data == '0));

  // R9
  src_zext_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(src_size) == 2'd0) |-> (src_data[XLEN-1:8] == '0));

  // R9
  dst_zext_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(dst_size) == 2'd1) |-> (dst_data[XLEN-1:16] == '0));

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    // R6
    narrow_keeps_upper_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_size[1] == 1'b0) |=> (regs_q[i][XLEN-1:16] == $past(regs_q[i][XLEN-1:16])));

    // R7
    word_zero_ext_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_size == 2'd2 && wr_sel == 3'(i)) |=> (regs_q[i][XLEN-1:XLEN/2] == '0));

    // R8
    full_write_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_size == 2'd3 && wr_sel == 3'(i)) |=> (regs_q[i] == $past(wr_data)));

    // R10
    others_stable_chk: assert property (@(posedge clk) disable iff (rst)
      !(wr_en && tgt == 3'(i)) |=> $stable(regs_q[i]));
  end
endmodule

bind alias_regfile alias_regfile_chk #(.XLEN(XLEN), .NREG(NREG)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .src_size (src_size),
  .dst_size (dst_size),
  .wr_en    (wr_en),
  .wr_sel   (wr_sel),
  .wr_size  (wr_size),
  .wr_pfx   (wr_pfx),
  .wr_data  (wr_data),
  .src_data (src_data),
  .dst_data (dst_data),
  .regs_q   (regs_q)
);

// File: tb/alias_regfile_bench.sv
`timescale 1ns/1ps
module alias_regfile_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  src_sel = '0, dst_sel = '0, wr_sel = '0;
  logic [1:0]  src_size = '0, dst_size = '0, wr_size = '0;
  logic        src_pfx = 1'b0, dst_pfx = 1'b0, wr_pfx = 1'b0, wr_en = 1'b0;
  logic [63:0] wr_data = '0;
  logic [63:0] src_data, dst_data;

  always #10 clk = ~clk;

  alias_regfile u_alias_regfile (
    .clk(clk), .rst(rst),
    .src_sel(src_sel), .src_size(src_size), .src_pfx(src_pfx),
    .dst_sel(dst_sel), .dst_size(dst_size), .dst_pfx(dst_pfx),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_size(wr_size), .wr_pfx(wr_pfx),
    .wr_data(wr_data), .src_data(src_data), .dst_data(dst_data)
  );

  typedef struct {
    logic [63:0] exp_s;
    logic [63:0] exp_d;
    string       tag;
  } item_t;

  item_t       sb[$];
  logic [63:0] model [8];
  int          checks = 0;
  int          errors = 0;
  bit          finished = 0;

  // Reference: which register and which byte lane an access names
  function automatic int m_reg(input logic [2:0] s, input logic [1:0] z, input logic p);
    if (z == 2'd0 && s >= 4 && !p) return int'(s) - 4;
    return int'(s);
  endfunction

  function automatic logic [63:0] m_read(input logic [2:0] s, input logic [1:0] z, input logic p);
    logic [63:0] r;
    r = model[m_reg(s, z, p)];
    case (z)
      2'd0: return (s >= 4 && !p) ? {56'd0, r[15:8]} : {56'd0, r[7:0]};
      2'd1: return {48'd0, r[15:0]};
      2'd2: return {32'd0, r[31:0]};
      default: return r;
    endcase
  endfunction

  task automatic m_write(input logic [2:0] s, input logic [1:0] z, input logic p, input logic [63:0] d);
    int k;
    k = m_reg(s, z, p);
    case (z)
      2'd0: if (s >= 4 && !p) model[k][15:8] = d[7:0]; else model[k][7:0] = d[7:0];
      2'd1: model[k][15:0] = d[15:0];
      2'd2: model[k] = {32'd0, d[31:0]};
      default: model[k] = d;
    endcase
  endtask

  task automatic cyc(input logic [2:0] ss, input logic [1:0] sz, input logic sp,
                     input logic [2:0] ds, input logic [1:0] dz, input logic dp,
                     input logic we, input logic [2:0] ws, input logic [1:0] wz,
                     input logic wp, input logic [63:0] wd, input string tag);
    item_t it;
    @(negedge clk);
    src_sel = ss; src_size = sz; src_pfx = sp;
    dst_sel = ds; dst_size = dz; dst_pfx = dp;
    wr_en = we; wr_sel = ws; wr_size = wz; wr_pfx = wp; wr_data = wd;
    it.exp_s = m_read(ss, sz, sp);
    it.exp_d = m_read(ds, dz, dp);
    it.tag = tag;
    sb.push_back(it);
    if (we) m_write(ws, wz, wp, wd);
  endtask

  task automatic rd(input logic [2:0] ss, input logic [1:0] sz, input logic sp,
                    input logic [2:0] ds, input logic [1:0] dz, input logic dp, input string tag);
    cyc(ss, sz, sp, ds, dz, dp, 1'b0, 3'd0, 2'd0, 1'b0, 64'd0, tag);
  endtask

  task automatic wr(input logic [2:0] ws, input logic [1:0] wz, input logic wp,
                    input logic [63:0] wd, input string tag);
    cyc(3'd0, 2'd3, 1'b0, 3'd0, 2'd3, 1'b0, 1'b1, ws, wz, wp, wd, tag);
  endtask

  // Monitor: one scoreboard item per driven cycle, result one edge later
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        checks++;
        if (src_data !== it.exp_s) begin
          errors++;
          $display("FAIL %s src: actual %h expected %h", it.tag, src_data, it.exp_s);
        end
        checks++;
        if (dst_data !== it.exp_d) begin
          errors++;
          $display("FAIL %s dst: actual %h expected %h", it.tag, dst_data, it.exp_d);
        end
      end
    end
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;

    // R1: every register zero after reset, at several sizes
    for (int i = 0; i < 8; i++) rd(3'(i), 2'd3, 1'b0, 3'(i), 2'd0, 1'b1, "R1 reset");

    // R8: fill with distinct full-width patterns
    for (int i = 0; i < 8; i++)
      wr(3'(i), 2'd3, 1'b0, 64'h1122334455667788 + 64'h0101010101010101 * 64'(i) * 64'h10, "R8 fill");
    for (int i = 0; i < 8; i++) rd(3'(i), 2'd3, 1'b0, 3'(i), 2'd3, 1'b1, "R8 full read");

    // R2, R3, R4: byte aliases with and without prefix
    for (int i = 0; i < 8; i++) rd(3'(i), 2'd0, 1'b0, 3'(i), 2'd0, 1'b1, "R2 R3 R4 byte alias");

    // R5, R9: 16/32-bit names, prefix ignored
    for (int i = 0; i < 8; i++) rd(3'(i), 2'd1, 1'b1, 3'(i), 2'd2, 1'b1, "R5 R9 half word");

    // R3, R6: write upper byte alias without prefix, reg 0 bits 15:8
    wr(3'd4, 2'd0, 1'b0, 64'hFFFF_FFFF_FFFF_FFAB, "R3 R6 hi byte write");
    rd(3'd0, 2'd3, 1'b0, 3'd4, 2'd3, 1'b0, "R3 R6 merge check");
    // R4: same selector with prefix hits reg 4 low byte
    wr(3'd4, 2'd0, 1'b1, 64'h0000_0000_0000_00CD, "R4 low byte write");
    rd(3'd4, 2'd3, 1'b0, 3'd0, 2'd3, 1'b0, "R4 merge check");
    // R6: 16-bit merge
    wr(3'd6, 2'd1, 1'b0, 64'hAAAA_BBBB_CCCC_5A5A, "R6 half write");
    rd(3'd6, 2'd3, 1'b0, 3'd6, 2'd1, 1'b0, "R6 half merge");
    // R7: 32-bit write clears upper half
    wr(3'd3, 2'd3, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, "R8 ones");
    wr(3'd3, 2'd2, 1'b1, 64'hDEAD_BEEF_1234_5678, "R7 word write");
    rd(3'd3, 2'd3, 1'b0, 3'd7, 2'd0, 1'b0, "R7 zero extend");

    // R10: same-cycle read sees old value, next cycle sees new
    cyc(3'd2, 2'd3, 1'b0, 3'd2, 2'd0, 1'b0, 1'b1, 3'd2, 2'd3, 1'b0, 64'h0F0E0D0C0B0A0908, "R10 read before write");
    rd(3'd2, 2'd3, 1'b0, 3'd1, 2'd3, 1'b0, "R10 visible next");

    // Random mix against the model
    for (int n = 0; n < 400; n++) begin
      logic [31:0] a;
      a = $urandom;
      cyc(a[2:0], a[4:3], a[5], a[8:6], a[10:9], a[11], a[12], a[15:13], a[17:16], a[18],
          {$urandom, $urandom}, "R2 R3 R4 R5 R6 R7 R8 R9 random mix");
    end

    // R1: reset again clears everything
    @(negedge clk);
    rst = 1'b1;
    wr_en = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 8; i++) model[i] = '0;
    for (int i = 0; i < 8; i++) rd(3'(i), 2'd3, 1'b0, 3'(i), 2'd1, 1'b0, "R1 second reset");

    @(negedge clk);
    wr_en = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule